// File: doc/BRIEF.md
# 64-bit Integer Execute ALU

This block is the arithmetic stage of a 64-bit integer core. It is purely combinational. The core presents an operation code, two 64-bit source operands, a 12-bit immediate with a select bit, a 20-bit upper immediate and the program counter. In the same cycle the block returns the value to be written to the destination register, together with a flag that says whether a conditional branch is taken.

Full-width operations cover add, subtract, the logic functions, set-less-than and shifts. A second group works on the low 32 bits and sign-extends its 32-bit result to 64 bits. The block also forms the two upper-immediate results and evaluates the six branch conditions. Decoding, register storage, memory access and next-PC selection belong to neighbouring blocks.

Top module: `int_exec_alu`

## Requirements
- R1: `op` is encoded as follows: 0 add, 1 sub, 2 sll, 3 slt, 4 sltu, 5 xor, 6 srl, 7 sra, 8 or, 9 and, 10 addw, 11 subw, 12 sllw, 13 srlw, 14 sraw, 15 lui, 16 auipc, 17 beq, 18 bne, 19 blt, 20 bge, 21 bltu, 22 bgeu. Codes 23 to 31 give `result` = 0 and `taken` = 0.
- R2: For codes 0 to 14 the second operand is `src_b` when `use_imm` = 0. When `use_imm` = 1 it is `imm12` sign-extended to 64 bits. Add, sub, xor, or and and return the 64-bit wrapped result.
- R3: Codes 3 and 4 return 1 when `src_a` is below the second operand, compared signed for code 3 and unsigned for code 4, and return 0 otherwise. Bits 63:1 are zero. The immediate is sign-extended even for the unsigned compare.
- R4: Codes 2 and 6 shift `src_a` by bits 5:0 of the second operand only. Left shifts fill the vacated low bits with zeros and right shifts fill the vacated high bits with zeros.
- R5: Code 7 shifts `src_a` right by bits 5:0 of the second operand and fills the vacated bits with copies of bit 63.
- R6: Codes 10 and 11 add or subtract bits 31:0 of both operands, then copy bit 31 of the 32-bit result into bits 63:32. With `use_imm` = 1, code 10 is the add-immediate word form.
- R7: Codes 12, 13 and 14 shift bits 31:0 of `src_a` by bits 4:0 of the second operand. Code 14 fills with bit 31 of `src_a`. The 32-bit result is then sign-extended.
- R8: Code 15 returns `uimm` followed by twelve zero bits, sign-extended from bit 31 to 64 bits.
- R9: Code 16 returns `pc` plus the code 15 value, wrapped to 64 bits.
- R10: Codes 17 to 22 compare `src_a` with `src_b` (never the immediate) as equal, not equal, signed less, signed greater-or-equal, unsigned less and unsigned greater-or-equal, and drive `taken` with the outcome. For these codes `result` is 0.
- R11: `taken` is 0 for every code outside 17 to 22.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 5 | Operation code |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| imm12 | input | 12 | Short immediate |
| use_imm | input | 1 | Use the sign-extended short immediate as the second operand |
| uimm | input | 20 | Upper immediate |
| pc | input | 64 | Address of the current instruction |
| result | output | 64 | Destination value |
| taken | output | 1 | Branch condition outcome |

## Verification
Both outputs depend on the inputs with no register in the path, so each result is due zero cycles after its stimulus. The bench changes the inputs just after a falling clock edge. It samples `result` and `taken` two nanoseconds later, inside the same low phase, which is after the logic has settled and well away from the next rising edge. Each scenario task applies one operand set at a time and checks that set before it applies the next.

// File: rtl/int_exec_alu.sv
module int_exec_alu #(
  parameter int DW = 64
) (
  input  logic [4:0]    op,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic [11:0]   imm12,
  input  logic          use_imm,
  input  logic [19:0]   uimm,
  input  logic [DW-1:0] pc,
  output logic [DW-1:0] result,
  output logic          taken
);
  localparam int SHW = $clog2(DW);
  localparam int HW  = DW / 2;

  localparam logic [4:0] C_ADD = 5'd0,  C_SUB = 5'd1,  C_SLL = 5'd2,  C_SLT = 5'd3;
  localparam logic [4:0] C_SLTU = 5'd4, C_XOR = 5'd5,  C_SRL = 5'd6,  C_SRA = 5'd7;
  localparam logic [4:0] C_OR = 5'd8,   C_AND = 5'd9,  C_ADDW = 5'd10, C_SUBW = 5'd11;
  localparam logic [4:0] C_SLLW = 5'd12, C_SRLW = 5'd13, C_SRAW = 5'd14;
  localparam logic [4:0] C_LUI = 5'd15, C_AUIPC = 5'd16;
  localparam logic [4:0] C_BEQ = 5'd17, C_BNE = 5'd18, C_BLT = 5'd19;
  localparam logic [4:0] C_BGE = 5'd20, C_BLTU = 5'd21, C_BGEU = 5'd22;

  logic [DW-1:0]  opnd_b;
  logic [SHW-1:0] sh_full;
  logic [4:0]     sh_word;
  logic [HW-1:0]  w_a, w_b, w_res;
  logic [DW-1:0]  upper;
  logic           lt_s, lt_u, br_lt_s, br_lt_u, br_eq;

  assign opnd_b  = use_imm ? {{(DW-12){imm12[11]}}, imm12} : src_b;
  assign sh_full = opnd_b[SHW-1:0];
  assign sh_word = opnd_b[4:0];
  assign w_a     = src_a[HW-1:0];
  assign w_b     = opnd_b[HW-1:0];
  assign upper   = {{(DW-32){uimm[19]}}, uimm, 12'h000};

  assign lt_s    = $signed(src_a) < $signed(opnd_b);
  assign lt_u    = src_a < opnd_b;
  assign br_lt_s = $signed(src_a) < $signed(src_b);
  assign br_lt_u = src_a < src_b;
  assign br_eq   = src_a == src_b;

  always_comb begin
    case (op)
      C_ADDW:  w_res = w_a + w_b;
      C_SUBW:  w_res = w_a - w_b;
      C_SLLW:  w_res = w_a << sh_word;
      C_SRLW:  w_res = w_a >> sh_word;
      C_SRAW:  w_res = $unsigned($signed(w_a) >>> sh_word);
      default: w_res = '0;
    endcase
  end

  always_comb begin
    result = '0;
    taken  = 1'b0;
    case (op)
      C_ADD:   result = src_a + opnd_b;
      C_SUB:   result = src_a - opnd_b;
      C_SLL:   result = src_a << sh_full;
      C_SLT:   result = {{(DW-1){1'b0}}, lt_s};
      C_SLTU:  result = {{(DW-1){1'b0}}, lt_u};
      C_XOR:   result = src_a ^ opnd_b;
      C_SRL:   result = src_a >> sh_full;
      C_SRA:   result = $unsigned($signed(src_a) >>> sh_full);
      C_OR:    result = src_a | opnd_b;
      C_AND:   result = src_a & opnd_b;
      C_ADDW, C_SUBW, C_SLLW, C_SRLW, C_SRAW:
               result = {{(DW-HW){w_res[HW-1]}}, w_res};
      C_LUI:   result = upper;
      C_AUIPC: result = pc + upper;
      C_BEQ:   taken = br_eq;
      C_BNE:   taken = !br_eq;
      C_BLT:   taken = br_lt_s;
      C_BGE:   taken = !br_lt_s;
      C_BLTU:  taken = br_lt_u;
      C_BGEU:  taken = !br_lt_u;
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown(op)) begin
      AST_UNDEF_QUIET: assert (op <= C_BGEU || (result == '0 && !taken)); // R1
      AST_SLT_BOOL: assert (!(op == C_SLT || op == C_SLTU) || result[DW-1:1] == '0); // R3
      AST_WORD_SEXT: assert (!(op >= C_ADDW && op <= C_SRAW) || result[DW-1:HW] == {(DW-HW){result[HW-1]}}); // R6
      AST_LUI_LOW: assert (op != C_LUI || result[11:0] == 12'h000); // R8
      AST_BR_NORES: assert (!(op >= C_BEQ && op <= C_BGEU) || result == '0); // R10
      AST_TAKEN_BR_ONLY: assert (!taken || (op >= C_BEQ && op <= C_BGEU)); // R11
    end
  end
endmodule

// File: tb/int_exec_alu_tb_top.sv
module int_exec_alu_tb_top;
  logic        clk = 1'b0;
  logic [4:0]  op = '0;
  logic [63:0] src_a = '0, src_b = '0, pc = '0;
  logic [11:0] imm12 = '0;
  logic        use_imm = 1'b0;
  logic [19:0] uimm = '0;
  logic [63:0] result;
  logic        taken;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  int_exec_alu dut_i (.op(op), .src_a(src_a), .src_b(src_b), .imm12(imm12),
    .use_imm(use_imm), .uimm(uimm), .pc(pc), .result(result), .taken(taken));

  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic void ref_model(input logic [4:0] o, input logic [63:0] a, input logic [63:0] b,
      input logic [11:0] im, input logic ui, input logic [19:0] up, input logic [63:0] p,
      output logic [63:0] r, output logic t);
    logic [63:0] bb, u;
    logic [31:0] aw;
    bb = ui ? 64'($signed(im)) : b;
    aw = a[31:0];
    u  = 64'($signed({up, 12'h000}));
    r = 64'd0; t = 1'b0;
    case (o)
      0: r = a + bb;
      1: r = a + (~bb + 64'd1);
      2: r = a << bb[5:0];
      3: r = ($signed(a) < $signed(bb)) ? 64'd1 : 64'd0;
      4: r = (a < bb) ? 64'd1 : 64'd0;
      5: r = a ^ bb;
      6: r = a >> bb[5:0];
      7: r = (a >> bb[5:0]) | (a[63] ? ~(ONES >> bb[5:0]) : 64'd0);
      8: r = a | bb;
      9: r = a & bb;
      10: r = sx32(aw + bb[31:0]);
      11: r = sx32(aw - bb[31:0]);
      12: r = sx32(aw << bb[4:0]);
      13: r = sx32(aw >> bb[4:0]);
      14: r = sx32((aw >> bb[4:0]) | (aw[31] ? ~(32'hFFFF_FFFF >> bb[4:0]) : 32'd0));
      15: r = u;
      16: r = p + u;
      17: t = a == b;
      18: t = a != b;
      19: t = $signed(a) < $signed(b);
      20: t = $signed(a) >= $signed(b);
      21: t = a < b;
      22: t = a >= b;
      default: ;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] exp_r, input logic exp_t);
    total++;
    if (result !== exp_r || taken !== exp_t) begin
      bad++;
      $display("FAIL %s op=%0d result=%h taken=%b expected result=%h taken=%b",
               tag, op, result, taken, exp_r, exp_t);
    end
  endtask

  task automatic apply(input logic [4:0] o, input logic [63:0] a, input logic [63:0] b,
      input logic [11:0] im, input logic ui, input logic [19:0] up, input logic [63:0] p);
    @(negedge clk);
    op = o; src_a = a; src_b = b; imm12 = im; use_imm = ui; uimm = up; pc = p;
    #2;
  endtask

  task automatic t_idle;
    apply(0, 0, 0, 0, 0, 0, 0);
    check("R2 idle add", 64'd0, 1'b0);
  endtask

  task automatic t_undef;
    for (int c = 23; c < 32; c++) begin
      apply(5'(c), ONES, MINV, 12'hFFF, 1'b0, 20'hFFFFF, ONES);
      check("R1 undefined code", 64'd0, 1'b0);
    end
  endtask

  task automatic t_arith;
    apply(0, ONES, 64'd1, 0, 0, 0, 0);            check("R2 add wrap", 64'd0, 1'b0);
    apply(1, MINV, 64'd1, 0, 0, 0, 0);            check("R2 sub", 64'h7FFF_FFFF_FFFF_FFFF, 1'b0);
    apply(0, 64'd10, ONES, 12'hFFE, 1, 0, 0);     check("R2 add immediate negative", 64'd8, 1'b0);
    apply(9, ONES, 64'd0, 12'h800, 1, 0, 0);      check("R2 and immediate", 64'hFFFF_FFFF_FFFF_F800, 1'b0);
    apply(5, 64'hF0F0, 64'h0FF0, 0, 0, 0, 0);     check("R2 xor", 64'hFF00, 1'b0);
    apply(8, 64'hF000, 64'h000F, 0, 0, 0, 0);     check("R2 or", 64'hF00F, 1'b0);
  endtask

  task automatic t_compare;
    apply(3, MINV, 64'd0, 0, 0, 0, 0);            check("R3 slt negative", 64'd1, 1'b0);
    apply(4, MINV, 64'd0, 0, 0, 0, 0);            check("R3 sltu", 64'd0, 1'b0);
    apply(4, 64'd5, 64'd0, 12'hFFF, 1, 0, 0);     check("R3 sltu immediate sign-extended", 64'd1, 1'b0);
    apply(3, 64'd5, 64'd0, 12'hFFF, 1, 0, 0);     check("R3 slt immediate", 64'd0, 1'b0);
  endtask

  task automatic t_shift64;
    apply(2, 64'd1, 64'd63, 0, 0, 0, 0);          check("R4 sll by 63", MINV, 1'b0);
    apply(2, 64'h1234, 64'h40, 0, 0, 0, 0);       check("R4 sll amount masked to 0", 64'h1234, 1'b0);
    apply(6, ONES, 64'd32, 0, 0, 0, 0);           check("R4 srl by 32", 64'h0000_0000_FFFF_FFFF, 1'b0);
    apply(6, MINV, 64'd63, 0, 0, 0, 0);           check("R4 srl by 63", 64'd1, 1'b0);
    apply(7, MINV, 64'd63, 0, 0, 0, 0);           check("R5 sra by 63", ONES, 1'b0);
    apply(7, MINV, 64'd0, 0, 0, 0, 0);            check("R5 sra by 0", MINV, 1'b0);
    apply(7, 64'h4000_0000_0000_0000, 64'd31, 0, 0, 0, 0); check("R5 sra positive", 64'h0000_0000_8000_0000, 1'b0);
  endtask

  task automatic t_word;
    apply(10, 64'h7FFF_FFFF, 64'd1, 0, 0, 0, 0); check("R6 addw overflow", 64'hFFFF_FFFF_8000_0000, 1'b0);
    apply(11, 64'hAAAA_0000_0000_0000, 64'd1, 0, 0, 0, 0); check("R6 subw", ONES, 1'b0);
    apply(10, 64'h1_0000_0005, 0, 12'hFFF, 1, 0, 0); check("R6 addiw", 64'd4, 1'b0);
    apply(12, 64'd1, 64'd31, 0, 0, 0, 0);         check("R7 sllw by 31", 64'hFFFF_FFFF_8000_0000, 1'b0);
    apply(13, 64'hFFFF_FFFF_8000_0000, 64'd31, 0, 0, 0, 0); check("R7 srlw by 31", 64'd1, 1'b0);
    apply(14, 64'h8000_0000, 64'd32, 0, 0, 0, 0); check("R7 sraw amount masked", 64'hFFFF_FFFF_8000_0000, 1'b0);
    apply(14, 64'h8000_0000, 64'd31, 0, 0, 0, 0); check("R7 sraw by 31", ONES, 1'b0);
  endtask

  task automatic t_upper;
    apply(15, ONES, ONES, 0, 0, 20'h80000, ONES); check("R8 lui negative", 64'hFFFF_FFFF_8000_0000, 1'b0);
    apply(15, 0, 0, 0, 0, 20'h12345, 0);           check("R8 lui positive", 64'h1234_5000, 1'b0);
    apply(16, 0, 0, 0, 0, 20'd1, 64'h1000);        check("R9 auipc", 64'h2000, 1'b0);
    apply(16, 0, 0, 0, 0, 20'hFFFFF, 64'h1000);    check("R9 auipc negative", 64'd0, 1'b0);
  endtask

  task automatic t_branch;
    apply(17, 64'd7, 64'd7, 12'h001, 1, 0, 0);     check("R10 beq ignores immediate", 64'd0, 1'b1);
    apply(18, 64'd7, 64'd7, 0, 0, 0, 0);           check("R10 bne", 64'd0, 1'b0);
    apply(19, ONES, 64'd0, 0, 0, 0, 0);            check("R10 blt", 64'd0, 1'b1);
    apply(20, ONES, 64'd0, 0, 0, 0, 0);            check("R10 bge", 64'd0, 1'b0);
    apply(21, ONES, 64'd0, 0, 0, 0, 0);            check("R10 bltu", 64'd0, 1'b0);
    apply(22, ONES, 64'd0, 0, 0, 0, 0);            check("R10 bgeu", 64'd0, 1'b1);
    apply(0, 64'd7, 64'd7, 0, 0, 0, 0);            check("R11 no taken for add", 64'd14, 1'b0);
  endtask

  task automatic t_random;
    logic [63:0] er, a, b, p;
    logic et;
    for (int c = 0; c < 23; c++) begin
      for (int k = 0; k < 40; k++) begin
        a = {$urandom, $urandom};
        b = (k % 4 == 0) ? a : {$urandom, $urandom};
        p = {$urandom, $urandom};
        if (k == 1) a = MINV;
        if (k == 2) b = ONES;
        apply(5'(c), a, b, 12'($urandom), 1'($urandom), 20'($urandom), p);
        ref_model(op, src_a, src_b, imm12, use_imm, uimm, pc, er, et);
        check("R2-R11 random vs model", er, et);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_idle;
    t_undef;
    t_arith;
    t_compare;
    t_shift64;
    t_word;
    t_upper;
    t_branch;
    t_random;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule